// File: doc/BRIEF.md
# Keyed Configuration Item Reader

This block lets a host fetch small, fixed configuration items by key. The host writes a 16-bit key to a selector register. It then pulls the selected item's bytes through a data register in accesses of one to eight bytes. Each byte handed out moves an internal byte offset forward. Items live in two internal tables: a shared table and an architecture-local table. Key bit 14 picks the table, and key bits 13:0 index into it. Each item has its own length. The tables are filled through a side load port before use.

A multi-byte read places the first item byte in the most significant byte of the requested width. When the item runs out before the access is full, the low-order positions are filled with zeros. A key whose index is at or above the slot limit leaves the block with no valid selection, and reads then return zero. After reset, key 0 (the identifier item) is selected at offset 0.

The access bus addresses one of four ports with `acc_port`:
- 0: the control register. It accepts only 2-byte writes.
- 1: the data register.
- 2: a combined register. A 1-byte read is a data read and a 2-byte write is a selector write.
- 3: unmapped.

Top module: `cfg_item_reader`

## Requirements
- R1: A selector write updates the current key and clears the byte offset to zero. A selector write is a 2-byte write (`acc_size`=2, value in `acc_wdata`) to port 0 or port 2. Reselecting the same key therefore restarts the item at its first byte.
- R2: A key whose bits 13:0 are not below FIRST_FILE+FILE_SLOTS (8 by default) leaves no valid selection. Key bit 15 is ignored. Every data read then returns zero.
- R3: Key bit 14 selects the architecture-local table. The index bits address that table separately from the shared table, so keys 0x0001 and 0x4001 read different items.
- R4: A data read of N bytes (N from 1 to 8) returns N consecutive item bytes from the current offset in the low N bytes of `rd_data`. The first byte sits in the most significant of those N bytes, and all bits above byte N-1 are zero. The offset advances by N.
- R5: When fewer than N bytes remain, the remaining bytes are returned followed by zero bytes in the lower positions. The offset stops at the item length and never passes it.
- R6: A data read returns zero and leaves the offset unchanged in any of these cases: the selection is invalid, the item is empty, the offset has reached the item length, or the size is outside 1..8.
- R7: Writes to the data port (port 1), and 1-byte writes to port 2, have no effect on the selection, the offset or the item contents.
- R8: After reset `rd_valid` is low and key 0 is selected at offset 0, so the first 4-byte data read returns the identifier item's four bytes.
- R9: On port 2, a 1-byte read is a data read and a 2-byte write is a selector write. A read of any other size returns zero without moving the offset.
- R10: On port 0, writes of any size other than 2 are ignored, and reads return zero without moving the offset.
- R11: Every read access (`acc_write`=0) produces `rd_valid`=1 with its data in the next cycle. No `rd_valid` follows a write or an idle cycle. Reads of port 3 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_port | input | 2 | 0 control, 1 data, 2 combined, 3 unmapped |
| acc_size | input | 4 | Access width in bytes |
| acc_wdata | input | 16 | Write value (selector key) |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 64 | Read response data |
| ld_we | input | 1 | Load one item byte |
| ld_len_we | input | 1 | Load one item length |
| ld_arch | input | 1 | Load target table (1 = architecture-local) |
| ld_idx | input | IDX_W | Load target item index |
| ld_offs | input | OFF_W | Load byte position in item |
| ld_byte | input | 8 | Byte value to load |
| ld_len | input | LEN_W | Item length to load |

## Verification
Every read result is due exactly one cycle after its strobe: the response register and the offset register both update at the edge that samples the access. The bench therefore drives each access at a falling edge and samples `rd_valid` and `rd_data` just after the next rising edge. Effects on the offset are never probed internally. They show up in the bytes returned by the following read, which is checked against a reference model that tracks selection and offset from the requirements. Ignored writes are followed at once by a read whose expected byte depends on the offset being untouched.

// File: rtl/cfg_reader_pkg.sv
package cfg_reader_pkg;
  typedef enum logic [1:0] {
    PORT_CTL  = 2'd0,
    PORT_DATA = 2'd1,
    PORT_COMB = 2'd2,
    PORT_NONE = 2'd3
  } port_e;

  localparam int KEY_W     = 16;
  localparam int ARCH_BIT  = 14;
  localparam int BUS_BYTES = 8;
  localparam int OFFS_W    = 32;
endpackage

// File: rtl/cfg_item_store.sv
// Two item tables (shared, architecture-local) held in flops.
// ITEMS and MAX_BYTES must be powers of two so the address is a plain concatenation.
module cfg_item_store #(
  parameter int ITEMS     = 8,
  parameter int MAX_BYTES = 16,
  parameter int IDX_W     = 3,
  parameter int OFF_W     = 4,
  parameter int LEN_W     = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_we,
  input  logic                    ld_len_we,
  input  logic                    ld_arch,
  input  logic [IDX_W-1:0]        ld_idx,
  input  logic [OFF_W-1:0]        ld_offs,
  input  logic [7:0]              ld_byte,
  input  logic [LEN_W-1:0]        ld_len,
  input  logic                    rd_arch,
  input  logic [IDX_W-1:0]        rd_idx,
  input  logic [cfg_reader_pkg::OFFS_W-1:0] rd_base,
  output logic [LEN_W-1:0]        rd_len,
  output logic [cfg_reader_pkg::BUS_BYTES*8-1:0] rd_win
);
  import cfg_reader_pkg::*;

  localparam int DEPTH  = 2 * ITEMS * MAX_BYTES;
  localparam int NSLOTS = 2 * ITEMS;

  logic [7:0]       byte_q [DEPTH];
  logic [LEN_W-1:0] len_q  [NSLOTS];

  always_ff @(posedge clk) begin
    if (ld_we) byte_q[{ld_arch, ld_idx, ld_offs}] <= ld_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOTS; s++) len_q[s] <= '0;
    end else if (ld_len_we) begin
      len_q[{ld_arch, ld_idx}] <= ld_len;
    end
  end

  assign rd_len = len_q[{rd_arch, rd_idx}];

  for (genvar g = 0; g < BUS_BYTES; g++) begin : g_lane
    logic [OFFS_W-1:0] pos;
    assign pos = rd_base + OFFS_W'(g);
    assign rd_win[g*8 +: 8] = (pos < OFFS_W'(MAX_BYTES))
                              ? byte_q[{rd_arch, rd_idx, pos[OFF_W-1:0]}] : 8'h00;
  end
endmodule

// File: rtl/cfg_sel_ctl.sv
// Current selection and byte offset.
module cfg_sel_ctl #(
  parameter int LIMIT = 8,
  parameter int IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel_we,
  input  logic [13:0]          sel_index,
  input  logic                 sel_arch,
  input  logic [3:0]           adv_cnt,
  output logic                 cur_valid,
  output logic                 cur_arch,
  output logic [IDX_W-1:0]     cur_idx,
  output logic [cfg_reader_pkg::OFFS_W-1:0] cur_off
);
  import cfg_reader_pkg::*;

  logic              valid_d, arch_d;
  logic [IDX_W-1:0]  idx_d;
  logic [OFFS_W-1:0] off_d;

  always_comb begin
    valid_d = cur_valid;
    arch_d  = cur_arch;
    idx_d   = cur_idx;
    off_d   = cur_off + OFFS_W'(adv_cnt);
    if (sel_we) begin
      valid_d = (sel_index < 14'(LIMIT));
      arch_d  = sel_arch;
      idx_d   = sel_index[IDX_W-1:0];
      off_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_valid <= 1'b1;
      cur_arch  <= 1'b0;
      cur_idx   <= '0;
      cur_off   <= '0;
    end else begin
      cur_valid <= valid_d;
      cur_arch  <= arch_d;
      cur_idx   <= idx_d;
      cur_off   <= off_d;
    end
  end

  assert_sel_clears_offset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> (cur_off == '0));

  assert_bad_key_invalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we && sel_index >= 14'(LIMIT)) |=> !cur_valid);
endmodule

// File: rtl/cfg_byte_pack.sv
// Packs up to eight item bytes, first byte most significant, zero padded on the right.
module cfg_byte_pack #(
  parameter int LEN_W = 5
) (
  input  logic                 sel_valid,
  input  logic [LEN_W-1:0]     item_len,
  input  logic [cfg_reader_pkg::OFFS_W-1:0] cur_off,
  input  logic [3:0]           size,
  input  logic [cfg_reader_pkg::BUS_BYTES*8-1:0] win,
  output logic [cfg_reader_pkg::BUS_BYTES*8-1:0] packed_data,
  output logic [3:0]           take
);
  import cfg_reader_pkg::*;

  logic [OFFS_W-1:0] len_ext, avail;
  logic              size_ok;

  assign len_ext = OFFS_W'(item_len);
  assign size_ok = (size != 4'd0) && (size <= 4'(BUS_BYTES));

  always_comb begin
    if (!sel_valid || cur_off >= len_ext) avail = '0;
    else                                  avail = len_ext - cur_off;
    if (!size_ok)                         take = 4'd0;
    else if (avail < OFFS_W'(size))       take = avail[3:0];
    else                                  take = size;
  end

  always_comb begin
    packed_data = '0;
    for (int j = 0; j < BUS_BYTES; j++) begin
      int src;
      src = int'(size) - 1 - j;
      if (j < int'(size) && src < int'(take) && src >= 0)
        packed_data[j*8 +: 8] = win[src*8 +: 8];
    end
  end
endmodule

// File: rtl/cfg_item_reader.sv
module cfg_item_reader #(
  parameter int FIRST_FILE = 4,
  parameter int FILE_SLOTS = 4,
  parameter int MAX_BYTES  = 16,
  localparam int ITEMS = FIRST_FILE + FILE_SLOTS,
  localparam int IDX_W = $clog2(ITEMS),
  localparam int OFF_W = $clog2(MAX_BYTES),
  localparam int LEN_W = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [1:0]       acc_port,
  input  logic [3:0]       acc_size,
  input  logic [15:0]      acc_wdata,
  output logic             rd_valid,
  output logic [63:0]      rd_data,
  input  logic             ld_we,
  input  logic             ld_len_we,
  input  logic             ld_arch,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [OFF_W-1:0] ld_offs,
  input  logic [7:0]       ld_byte,
  input  logic [LEN_W-1:0] ld_len
);
  import cfg_reader_pkg::*;

  port_e port;
  assign port = port_e'(acc_port);

  logic rd_acc, data_rd, sel_we;
  logic unused_key_msb;
  assign unused_key_msb = acc_wdata[15];

  assign rd_acc  = acc_valid && !acc_write;
  assign data_rd = rd_acc && ((port == PORT_DATA) ||
                              (port == PORT_COMB && acc_size == 4'd1));
  assign sel_we  = acc_valid && acc_write && (acc_size == 4'd2) &&
                   ((port == PORT_CTL) || (port == PORT_COMB));

  logic              cur_valid, cur_arch;
  logic [IDX_W-1:0]  cur_idx;
  logic [OFFS_W-1:0] cur_off;
  logic [LEN_W-1:0]  item_len;
  logic [63:0]       win, packed_data;
  logic [3:0]        take, eff_size;

  assign eff_size = data_rd ? acc_size : 4'd0;

  cfg_sel_ctl #(.LIMIT(ITEMS), .IDX_W(IDX_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we),
    .sel_index(acc_wdata[13:0]), .sel_arch(acc_wdata[ARCH_BIT]),
    .adv_cnt(take),
    .cur_valid(cur_valid), .cur_arch(cur_arch), .cur_idx(cur_idx), .cur_off(cur_off)
  );

  cfg_item_store #(.ITEMS(ITEMS), .MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W),
                   .OFF_W(OFF_W), .LEN_W(LEN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_len_we(ld_len_we),
    .ld_arch(ld_arch), .ld_idx(ld_idx), .ld_offs(ld_offs), .ld_byte(ld_byte),
    .ld_len(ld_len), .rd_arch(cur_arch), .rd_idx(cur_idx), .rd_base(cur_off),
    .rd_len(item_len), .rd_win(win)
  );

  cfg_byte_pack #(.LEN_W(LEN_W)) u_pack (
    .sel_valid(cur_valid), .item_len(item_len), .cur_off(cur_off),
    .size(eff_size), .win(win), .packed_data(packed_data), .take(take)
  );

  logic        rd_valid_d;
  logic [63:0] rd_data_d;

  always_comb begin
    rd_valid_d = rd_acc;
    rd_data_d  = data_rd ? packed_data : 64'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_valid_d;
      rd_data  <= rd_data_d;
    end
  end

  assert_read_answered_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rd_valid);

  assert_no_spurious_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !rd_valid);

  assert_one_byte_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && acc_size == 4'd1) |=> (rd_data[63:8] == 56'd0));

  assert_offset_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cur_valid |-> (cur_off <= OFFS_W'(item_len)));

  assert_data_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && port == PORT_DATA) |=> $stable(cur_off));
endmodule

// File: tb/cfg_item_reader_test.sv
module cfg_item_reader_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write;
  logic [1:0]  acc_port;
  logic [3:0]  acc_size;
  logic [15:0] acc_wdata;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic        ld_we, ld_len_we, ld_arch;
  logic [2:0]  ld_idx;
  logic [3:0]  ld_offs;
  logic [7:0]  ld_byte;
  logic [4:0]  ld_len;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  bit m_valid, m_arch;
  int m_idx, m_off;
  int m_len [2][8];

  always #2 clk = ~clk;

  cfg_item_reader uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_port(acc_port), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ld_we(ld_we), .ld_len_we(ld_len_we),
    .ld_arch(ld_arch), .ld_idx(ld_idx), .ld_offs(ld_offs), .ld_byte(ld_byte),
    .ld_len(ld_len)
  );

  function automatic logic [7:0] item_byte(bit arch, int idx, int i);
    if (!arch && idx == 0) begin
      case (i)
        0: return 8'h43;
        1: return 8'h46;
        2: return 8'h47;
        default: return 8'h53;
      endcase
    end
    return ~{arch, 3'(idx), 4'(i)};
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic load_item(bit arch, int idx, int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      ld_we = 1; ld_arch = arch; ld_idx = 3'(idx); ld_offs = 4'(i);
      ld_byte = item_byte(arch, idx, i);
    end
    @(negedge clk);
    ld_we = 0; ld_len_we = 1; ld_arch = arch; ld_idx = 3'(idx); ld_len = 5'(len);
    @(negedge clk);
    ld_len_we = 0;
    m_len[arch][idx] = len;
  endtask

  // One access, checked against the model; the response is sampled after the next rising edge.
  task automatic acc(string tag, int port, bit wr, int size, logic [15:0] wd);
    logic [63:0] exp;
    bit is_data;
    exp = 0;
    is_data = !wr && (port == 1 || (port == 2 && size == 1));
    if (is_data && size >= 1 && size <= 8) begin
      for (int i = 0; i < size; i++) begin
        if (m_valid && m_off < m_len[m_arch][m_idx]) begin
          exp = (exp << 8) | 64'(item_byte(m_arch, m_idx, m_off));
          m_off++;
        end else begin
          exp = exp << 8;
        end
      end
    end
    if (wr && size == 2 && (port == 0 || port == 2)) begin
      m_valid = (wd[13:0] < 14'd8);
      m_arch  = wd[14];
      m_idx   = int'(wd[2:0]);
      m_off   = 0;
    end
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_port = 2'(port); acc_size = 4'(size); acc_wdata = wd;
    @(posedge clk);
    #1;
    acc_valid = 0;
    if (wr) begin
      check({tag, "/R11 no response to write"}, 64'(rd_valid), 64'd0);
    end else begin
      check({tag, "/R11 response strobe"}, 64'(rd_valid), 64'd1);
      check(tag, rd_data, exp);
    end
  endtask

  task automatic t_reset;
    check("R8 rd_valid low after reset", 64'(rd_valid), 64'd0);
    acc("R8 identifier read", 1, 0, 4, 16'h0);
    check("R8 identifier value", rd_data, 64'h43464753);
  endtask

  task automatic t_pack;
    acc("R1 select key 1", 0, 1, 2, 16'h0001);
    acc("R4 read 4", 1, 0, 4, 0);
    acc("R4 read 2", 1, 0, 2, 0);
    acc("R5 read 8 with 4 left", 1, 0, 8, 0);
    acc("R6 read past end", 1, 0, 8, 0);
    acc("R6 read 1 past end", 1, 0, 1, 0);
    acc("R1 reselect restarts", 0, 1, 2, 16'h0001);
    acc("R1 first byte again", 1, 0, 1, 0);
    acc("R4 select 16-byte item", 0, 1, 2, 16'h0005);
    acc("R4 full 8", 1, 0, 8, 0);
    acc("R4 second full 8", 1, 0, 8, 0);
    acc("R5 saturated", 1, 0, 3, 0);
  endtask

  task automatic t_arch;
    acc("R3 select local 1", 0, 1, 2, 16'h4001);
    acc("R3 local read", 1, 0, 5, 0);
    acc("R3 select shared 1", 0, 1, 2, 16'h0001);
    acc("R3 shared read", 1, 0, 5, 0);
    acc("R3 select local 2", 2, 1, 2, 16'h4002);
    acc("R3 local 2 read", 1, 0, 6, 0);
  endtask

  task automatic t_keys;
    acc("R2 select limit", 0, 1, 2, 16'h0008);
    acc("R2 read limit", 1, 0, 4, 0);
    acc("R2 select local limit", 0, 1, 2, 16'h4008);
    acc("R2 read local limit", 1, 0, 4, 0);
    acc("R2 select top slot", 0, 1, 2, 16'h0007);
    acc("R2 read top slot", 1, 0, 3, 0);
    acc("R2 select 0x3fff", 0, 1, 2, 16'h3FFF);
    acc("R2 read 0x3fff", 1, 0, 2, 0);
    acc("R2 bit15 ignored", 0, 1, 2, 16'h8007);
    acc("R2 read bit15 key", 1, 0, 2, 0);
  endtask

  task automatic t_empty;
    acc("R6 select empty", 0, 1, 2, 16'h0003);
    acc("R6 read empty", 1, 0, 2, 0);
    acc("R6 select 5", 0, 1, 2, 16'h0005);
    acc("R6 size 0 read", 1, 0, 0, 0);
    acc("R6 size 9 read", 1, 0, 9, 0);
    acc("R6 offset held", 1, 0, 1, 0);
  endtask

  task automatic t_datawrite;
    acc("R7 select 5", 0, 1, 2, 16'h0005);
    acc("R7 read 1", 1, 0, 1, 0);
    acc("R7 data write", 1, 1, 4, 16'hFFFF);
    acc("R7 data write size 2", 1, 1, 2, 16'h0001);
    acc("R7 next byte", 1, 0, 1, 0);
  endtask

  task automatic t_comb;
    acc("R9 comb select 2", 2, 1, 2, 16'h0002);
    acc("R9 comb read", 2, 0, 1, 0);
    acc("R7 comb 1-byte write", 2, 1, 1, 16'h0001);
    acc("R9 comb read 2", 2, 0, 1, 0);
    acc("R9 comb size2 read zero", 2, 0, 2, 0);
    acc("R9 comb read 3", 2, 0, 1, 0);
  endtask

  task automatic t_ctl;
    acc("R10 ctl 1-byte write", 0, 1, 1, 16'h0005);
    acc("R10 data after ignored", 1, 0, 1, 0);
    acc("R10 ctl 4-byte write", 0, 1, 4, 16'h0001);
    acc("R10 ctl read zero", 0, 0, 2, 0);
    acc("R10 data after ctl read", 1, 0, 1, 0);
    acc("R11 unmapped read", 3, 0, 4, 0);
    acc("R11 data after unmapped", 1, 0, 1, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    acc_valid = 0; acc_write = 0; acc_port = 0; acc_size = 0; acc_wdata = 0;
    ld_we = 0; ld_len_we = 0; ld_arch = 0; ld_idx = 0; ld_offs = 0; ld_byte = 0; ld_len = 0;
    for (int a = 0; a < 2; a++)
      for (int k = 0; k < 8; k++) m_len[a][k] = 0;
    m_valid = 1; m_arch = 0; m_idx = 0; m_off = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    load_item(0, 0, 4);
    load_item(0, 1, 10);
    load_item(0, 2, 6);
    load_item(0, 3, 0);
    load_item(0, 5, 16);
    load_item(0, 7, 3);
    load_item(1, 1, 5);
    load_item(1, 2, 4);
    t_reset();
    t_pack();
    t_arch();
    t_keys();
    t_empty();
    t_datawrite();
    t_comb();
    t_ctl();
    finish_run();
  end
endmodule